// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous serial frame on a single output line. A frame holds a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Bit timing comes from a base-clock tick made by an external prescaler, and every bit lasts a fixed number of those ticks. The line idles high.

Software brings the block up by raising the power enable first and the transmit enable second. It waits at least one base-clock tick and then writes a character into the single buffer. The mode fields (parity, length, stop bits) are captured together with the character. Dropping the transmit enable resets the whole transmit circuit at once. A re-enable must follow a low time that covers at least one base-clock tick. A shorter low time, or an enable held while power is off, is recorded as a protocol violation.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, txd_o is 1 and busy_o, done_o, overrun_o and proto_err_o are all 0.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. Each bit holds for TICKS_PER_BIT (16) ticks of tick_i. When len8_i is 1 the frame carries 8 data bits. When len8_i is 0 it carries 7 data bits (bits 6..0) and wr_data_i bit 7 is not sent.
- R3: par_sel_i selects the parity bit. 2'b00 sends no parity bit. 2'b01 sends a 0. 2'b10 sends odd parity, so the data bits sent plus the parity bit hold an odd number of ones. 2'b11 sends even parity.
- R4: stop2_i = 0 sends one stop bit and stop2_i = 1 sends two.
- R5: An accepted write raises busy_o in the next cycle while txd_o stays 1. The start bit begins on the first tick_i after that. busy_o stays 1 until the frame ends.
- R6: done_o is a one-cycle pulse. It follows the last tick of the last stop bit, and busy_o is 0 in that same cycle.
- R7: A write while busy_o is 1 does not change the frame in progress and sets overrun_o. overrun_o stays 1 until the transmitter is disabled.
- R8: While power_en_i or tx_en_i is 0, the transmit circuit is held in reset. From the next cycle on, txd_o is 1, busy_o is 0 and overrun_o is 0, and writes are ignored.
- R9: After the transmitter is enabled, writes are ignored until one tick_i has occurred with the transmitter enabled.
- R10: proto_err_o is set, and stays set until reset, when tx_en_i rises after a low time in which no tick_i occurred, or when tx_en_i is 1 while power_en_i is 0. A low time that contains a tick does not set it.
- R11: par_sel_i, len8_i and stop2_i are captured at the accepted write. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base-clock enable from the prescaler, one cycle wide |
| power_en_i | input | 1 | Power enable for the transmitter |
| tx_en_i | input | 1 | Transmit enable; 0 resets the transmit circuit |
| par_sel_i | input | 2 | Parity mode: 00 none, 01 zero, 10 odd, 11 even |
| len8_i | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| stop2_i | input | 1 | 1 selects two stop bits, 0 selects one |
| wr_en_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | DATA_W | Character to send |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame pending or in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| overrun_o | output | 1 | Sticky flag for a write attempt while busy |
| proto_err_o | output | 1 | Sticky enable-protocol violation flag |

## Verification
Every output is a register, so each effect of an input becomes visible one clock after the edge that samples it. busy_o, overrun_o, proto_err_o and the disable reset are therefore checked at the falling edge that follows the stimulus. The serial line is measured in tick counts, starting from the falling edge of the start bit. Each bit is sampled in the middle of its period, at tick 8 of 16. done_o is expected at exactly the falling clock edge after tick number nbits*16, and in no other cycle of the frame. The tick and all other inputs are driven one delay after the rising edge or at the falling edge, so the sampling never races the design.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_SEND = 2'b10
    } tx_state_e;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic power_en_i,
    input  logic tx_en_i,
    input  logic wr_en_i,
    input  logic busy_i,
    output logic enable_o,
    output logic accept_o,
    output logic overrun_o,
    output logic proto_err_o
);

    typedef struct packed {
        logic en_prev;
        logic saw_low_tick;
        logic ready;
        logic ovr;
        logic proto;
    } ctrl_s;

    localparam ctrl_s CTRL_RST = '{
        en_prev:      1'b0,
        saw_low_tick: 1'b1,
        ready:        1'b0,
        ovr:          1'b0,
        proto:        1'b0
    };

    ctrl_s ctl_d, ctl_q;
    logic  enable;
    logic  tx_rise;

    assign enable  = power_en_i & tx_en_i;
    assign tx_rise = tx_en_i & ~ctl_q.en_prev;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.en_prev = tx_en_i;

        if (tx_en_i) begin
            ctl_d.saw_low_tick = 1'b0;
        end else if (tick_i) begin
            ctl_d.saw_low_tick = 1'b1;
        end

        if (!enable) begin
            ctl_d.ready = 1'b0;
            ctl_d.ovr   = 1'b0;
        end else begin
            if (tick_i) begin
                ctl_d.ready = 1'b1;
            end
            if (wr_en_i && ctl_q.ready && busy_i) begin
                ctl_d.ovr = 1'b1;
            end
        end

        if ((tx_rise && !ctl_q.saw_low_tick) || (tx_en_i && !power_en_i)) begin
            ctl_d.proto = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTRL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign enable_o    = enable;
    assign accept_o    = enable & ctl_q.ready & wr_en_i & ~busy_i;
    assign overrun_o   = ctl_q.ovr;
    assign proto_err_o = ctl_q.proto;

    AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.proto |=> ctl_q.proto); // R10

    AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ovr && enable) |=> ctl_q.ovr); // R7

    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ctl_q.ovr); // R8

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [1:0]         par_i,
    input  logic               len8_i,
    input  logic               stop2_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   nbits_o
);

    par_mode_e         mode;
    logic [DATA_W-1:0] keep_mask;
    logic              ones_odd;
    logic              par_bit;
    int                n_data;
    int                pos;

    assign mode      = par_mode_e'(par_i);
    assign keep_mask = len8_i ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
    assign ones_odd  = ^(data_i & keep_mask);

    always_comb begin
        unique case (mode)
            PAR_ZERO: par_bit = 1'b0;
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_EVEN: par_bit = ones_odd;
            default:  par_bit = 1'b1;
        endcase
    end

    always_comb begin
        n_data     = len8_i ? DATA_W : DATA_W - 1;
        frame_o    = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n_data) begin
                frame_o[1 + i] = data_i[i];
            end
        end
        pos = 1 + n_data;
        if (mode != PAR_NONE) begin
            frame_o[pos] = par_bit;
            pos          = pos + 1;
        end
        nbits_o = CNT_W'(pos + 1 + int'(stop2_i));
    end

endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
    import uart_tx_pkg::*;
#(
    parameter int FRAME_W       = 12,
    parameter int TICKS_PER_BIT = 16,
    parameter int CNT_W         = $clog2(FRAME_W + 1),
    parameter int TC_W          = $clog2(TICKS_PER_BIT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   nbits_i,
    output logic               txd_o,
    output logic               busy_o,
    output logic               done_o
);

    localparam logic [TC_W-1:0] TC_LAST = TC_W'(TICKS_PER_BIT - 1);

    typedef struct packed {
        tx_state_e          state;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   nbits;
        logic [CNT_W-1:0]   idx;
        logic [TC_W-1:0]    tc;
        logic               txd;
        logic               done;
    } ser_s;

    localparam ser_s SER_RST = '{
        state: ST_IDLE,
        frame: '1,
        nbits: '0,
        idx:   '0,
        tc:    '0,
        txd:   1'b1,
        done:  1'b0
    };

    ser_s             ser_d, ser_q;
    logic [CNT_W-1:0] idx_next;
    logic [CNT_W-1:0] idx_last;

    assign idx_next = ser_q.idx + 1'b1;
    assign idx_last = ser_q.nbits - 1'b1;

    always_comb begin
        ser_d      = ser_q;
        ser_d.done = 1'b0;
        if (!enable_i) begin
            ser_d = SER_RST;
        end else begin
            unique case (ser_q.state)
                ST_IDLE: begin
                    if (load_i) begin
                        ser_d.frame = frame_i;
                        ser_d.nbits = nbits_i;
                        ser_d.state = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tick_i) begin
                        ser_d.state = ST_SEND;
                        ser_d.txd   = ser_q.frame[0];
                        ser_d.idx   = '0;
                        ser_d.tc    = '0;
                    end
                end
                ST_SEND: begin
                    if (tick_i) begin
                        if (ser_q.tc == TC_LAST) begin
                            ser_d.tc = '0;
                            if (ser_q.idx == idx_last) begin
                                ser_d.state = ST_IDLE;
                                ser_d.txd   = 1'b1;
                                ser_d.done  = 1'b1;
                            end else begin
                                ser_d.idx = idx_next;
                                ser_d.txd = ser_q.frame[idx_next];
                            end
                        end else begin
                            ser_d.tc = ser_q.tc + 1'b1;
                        end
                    end
                end
                default: ser_d = SER_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q <= SER_RST;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign txd_o  = ser_q.txd;
    assign busy_o = (ser_q.state != ST_IDLE);
    assign done_o = ser_q.done;

    AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (txd_o && !busy_o)); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6

    AST_WAIT_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_q.state == ST_WAIT) |-> txd_o); // R5

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              power_en_i,
    input  logic              tx_en_i,
    input  logic [1:0]        par_sel_i,
    input  logic              len8_i,
    input  logic              stop2_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              txd_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              overrun_o,
    output logic              proto_err_o
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               enable;
    logic               accept;
    logic               busy;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    uart_tx_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .power_en_i  (power_en_i),
        .tx_en_i     (tx_en_i),
        .wr_en_i     (wr_en_i),
        .busy_i      (busy),
        .enable_o    (enable),
        .accept_o    (accept),
        .overrun_o   (overrun_o),
        .proto_err_o (proto_err_o)
    );

    uart_tx_framer #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) i_framer (
        .data_i  (wr_data_i),
        .par_i   (par_sel_i),
        .len8_i  (len8_i),
        .stop2_i (stop2_i),
        .frame_o (frame),
        .nbits_o (nbits)
    );

    uart_tx_serial #(
        .FRAME_W       (FRAME_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CNT_W         (CNT_W)
    ) i_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .tick_i   (tick_i),
        .load_i   (accept),
        .frame_i  (frame),
        .nbits_i  (nbits),
        .txd_o    (txd_o),
        .busy_o   (busy),
        .done_o   (done_o)
    );

    assign busy_o = busy;

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o); // R5

    AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && busy_o && enable && $past(enable) && $past(busy_o)) |=> overrun_o); // R7

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;
    localparam int DIV        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       power_en = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       len8 = 1'b1;
    logic       stop2 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, busy, done, overrun, proto_err;

    int  errors = 0;
    int  checks = 0;
    bit  tick_on = 1'b0;

    uart_frame_tx i_uart_frame_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .power_en_i  (power_en),
        .tx_en_i     (tx_en),
        .par_sel_i   (par_sel),
        .len8_i      (len8),
        .stop2_i     (stop2),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .txd_o       (txd),
        .busy_o      (busy),
        .done_o      (done),
        .overrun_o   (overrun),
        .proto_err_o (proto_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin : tick_gen
        int cnt;
        cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            if (tick_on && cnt >= DIV) begin
                tick = 1'b1;
                cnt  = 0;
            end else begin
                tick = 1'b0;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] p,
                                              input logic l8, input logic s2, output int nb);
        logic [11:0] f;
        int          k;
        int          ones;
        f    = '1;
        f[0] = 1'b0;
        k    = 1;
        ones = 0;
        for (int i = 0; i < (l8 ? 8 : 7); i++) begin
            f[k] = d[i];
            ones += int'(d[i]);
            k++;
        end
        if (p != 2'b00) begin
            if (p == 2'b01)      f[k] = 1'b0;
            else if (p == 2'b10) f[k] = ~ones[0];
            else                 f[k] = ones[0];
            k++;
        end
        nb = k + 1 + int'(s2);
        return f;
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic [1:0] p, input logic l8,
                             input logic s2, input bit mid_write, input bit mid_mode);
        logic [11:0] exp;
        logic [11:0] got;
        logic [11:0] mask;
        int          nb;
        int          c;
        int          guard;
        bit          bad_done;
        bit          bad_busy;
        exp = exp_frame(d, p, l8, s2, nb);
        mask = 12'((13'h1 << nb) - 1);
        @(negedge clk);
        par_sel = p; len8 = l8; stop2 = s2; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 busy after write", 32'(busy), 32'd1);
        chk("R5 line high before start tick", 32'(txd), 32'd1);
        guard = 0;
        while (txd !== 1'b0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        c = 0; got = '1; bad_done = 1'b0; bad_busy = 1'b0; guard = 0;
        forever begin
            if ((c % TPB) == TPB/2 && (c / TPB) < nb) got[c / TPB] = txd;
            if (c == nb * TPB) break;
            if (done)  bad_done = 1'b1;
            if (!busy) bad_busy = 1'b1;
            if (mid_write && c == 40) begin
                wr_en = 1'b1; wr_data = ~d;
            end else begin
                wr_en = 1'b0;
            end
            if (mid_mode && c == 20) begin
                par_sel = 2'($urandom); len8 = 1'($urandom); stop2 = 1'($urandom);
            end
            if (tick) c++;
            guard++;
            if (guard > 5000) break;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R6 done at end of last stop bit", 32'(done), 32'd1);
        chk("R6 busy low with done", 32'(busy), 32'd0);
        chk(mid_mode ? "R11 frame bits unaffected by mode change" : "R2/R3/R4 frame bits",
            32'(got & mask), 32'(exp & mask));
        chk("R6 no early done", 32'(bad_done), 32'd0);
        chk("R5 busy through frame", 32'(bad_busy), 32'd0);
        if (mid_write) chk("R7 overrun set on busy write", 32'(overrun), 32'd1);
        @(negedge clk);
        chk("R6 done single cycle", 32'(done), 32'd0);
        chk("R2 line idle after frame", 32'(txd), 32'd1);
    endtask

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", 32'(txd), 32'd1);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 proto_err", 32'(proto_err), 32'd0);

        // R9: enable with no tick yet, write must be ignored
        tick_on = 1'b0;
        power_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 write before first tick ignored", 32'(busy), 32'd0);
        chk("R9 line stays idle", 32'(txd), 32'd1);
        chk("R10 ordered startup no violation", 32'(proto_err), 32'd0);
        tick_on = 1'b1;
        repeat (10) @(negedge clk);

        // directed parity, length and stop modes
        run_frame(8'hA5, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(8'h3C, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(8'h07, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
        run_frame(8'h07, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(8'hFF, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame(8'h80, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);

        // constrained random frames, some with mode changes mid frame
        for (int n = 0; n < 24; n++) begin
            run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'b0, ($urandom % 3) == 0);
        end

        // R7: write while busy
        run_frame(8'h96, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R7 overrun sticky", 32'(overrun), 32'd1);

        // R8: disable in mid frame
        @(negedge clk);
        par_sel = 2'b00; len8 = 1'b1; stop2 = 1'b0; wr_data = 8'h12; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (100) @(negedge clk);
        chk("R8 busy before disable", 32'(busy), 32'd1);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R8 line idle after disable", 32'(txd), 32'd1);
        chk("R8 busy cleared", 32'(busy), 32'd0);
        chk("R8 overrun cleared", 32'(overrun), 32'd0);
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 write while disabled ignored", 32'(busy), 32'd0);
        chk("R8 no done while disabled", 32'(done), 32'd0);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 long low time no violation", 32'(proto_err), 32'd0);
        repeat (10) @(negedge clk);
        run_frame(8'hC3, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);

        // R10: short low pulse without a tick
        tick_on = 1'b0;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R10 short low pulse flagged", 32'(proto_err), 32'd1);
        repeat (3) @(negedge clk);
        chk("R10 flag sticky", 32'(proto_err), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule